// File: doc/BRIEF.md
# Inline-Immediate Instruction Skip Address Unit

This unit finds where instruction fetch resumes after an 8-byte prefixed instruction that is followed by a packed run of 16-bit immediates. The instruction and its data are handled like an unconditional jump. The unit computes a fall-through address that lies past the instruction and past all of its padded data.

The first immediate sits inside the instruction word, so the data holds one fewer immediate than the maximum vector length. Each of these extra immediates takes 16 bits per sub-vector element. The data is padded to whole 32-bit words. The element width setting never changes the immediate size, so the unit has no port for it.

When the mode bit is low, the instruction is a plain 8-byte prefixed instruction. The unit also flags an alignment fault when the instruction plus its data runs past the end of the 64-byte fetch block it starts in. The result is registered and appears one cycle after the request, together with a one-cycle valid pulse.

Top module: `vimm_skip_pc`

## Requirements
- R1: After reset, `nextValid` is 0, `nextAddr` is 0 and `alignFault` is 0.
- R2: `nextValid` is 1 in exactly the cycle after each cycle in which `reqValid` is 1, and 0 otherwise. Back-to-back requests each give their own result.
- R3: With `vecImmEn` = 0, `nextAddr` = `curAddr` + 8 (modulo 2^ADDR_W), whatever `maxVl` and `subCode` are.
- R4: With `vecImmEn` = 1, `nextAddr` = `curAddr` + 8 + 4 × ceil(2 × (`maxVl` − 1) × n / 4), where n is the sub-vector element count.
- R5: `subCode` is an unsigned 2-bit code: the values 0, 1, 2 and 3 select n = 1, 2, 3 and 4 elements.
- R6: With `maxVl` = 1, the step is 8 bytes even when `vecImmEn` = 1.
- R7: `alignFault` is 1 exactly when (`curAddr` mod 64) plus the instruction length is greater than 64. An instruction that ends exactly on the block end does not fault.
- R8: In a cycle where `reqValid` is 0, `nextAddr` and `alignFault` keep their previous values, even if the other inputs change.
- R9: A `maxVl` of 0 is treated as 1. A value above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A computation is requested this cycle |
| curAddr | input | ADDR_W | Byte address of the prefixed instruction |
| maxVl | input | VL_W | Maximum vector length, 1 to 64 |
| subCode | input | SUB_W | Sub-vector length code: element count minus one |
| vecImmEn | input | 1 | Trailing immediate data is present |
| nextValid | output | 1 | One-cycle pulse: the result is valid |
| nextAddr | output | ADDR_W | Address of the following instruction |
| alignFault | output | 1 | The instruction plus its data crosses a 64-byte block |

## Verification
The bench sweeps every `maxVl` code from 0 to 64 and every sub-vector code, with the mode on and off, across block offsets that include the last word of a block and bases that wrap the address space. Each sweep is compared against an expected value worked out in bytes:
- Rounding the immediate count down instead of up would land `nextAddr` inside the data.
- Forgetting that the first immediate is inside the instruction would add one stray word.
- A comparison of `>=` instead of `>` in the fault test would fault on instructions that end exactly at the block edge.
- A result register that loads every cycle would fail the hold checks made while the inputs are scrambled.
- Back-to-back requests expose a valid strobe that does not follow each request.

// File: rtl/vimm_pkg.sv
package vimm_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // load a fresh result this cycle
    logic idle;      // no request: hold the result registers
  } vimmStrobe_t;

  // Fixed geometry of the encoding
  localparam int unsigned BASE_LEN_BYTES = 8;   // prefix + suffix
  localparam int unsigned IMM_BYTES      = 2;   // one 16-bit immediate
  localparam int unsigned WORD_BYTES     = 4;

endpackage

// File: rtl/vimm_len_calc.sv
// Combinational length and block-crossing evaluation.
module vimm_len_calc #(
  parameter int unsigned VL_W        = 7,
  parameter int unsigned MAX_VL      = 64,
  parameter int unsigned SUB_W       = 2,
  parameter int unsigned BLOCK_BYTES = 64,
  parameter int unsigned BLK_W       = 6,
  parameter int unsigned LEN_W       = 10
) (
  input  logic [VL_W-1:0]  maxVl,
  input  logic [SUB_W-1:0] subCode,
  input  logic             vecImmEn,
  input  logic [BLK_W-1:0] blockOffset,
  output logic [LEN_W-1:0] instLen,
  output logic             crossBlock
);
  import vimm_pkg::*;

  localparam int unsigned PROD_W = VL_W + SUB_W + 1;
  localparam int unsigned FULL_W = PROD_W + 2;
  localparam int unsigned END_W  = LEN_W + 1;

  logic [VL_W-1:0]   vlEff;
  logic [VL_W-1:0]   extraImm;
  logic [PROD_W-1:0] partialSum [SUB_W+1];
  logic [PROD_W-1:0] halfWords;
  logic [PROD_W-1:0] wordCount;
  logic [FULL_W-1:0] lenFull;
  logic [END_W-1:0]  endOffset;

  // Clamp the vector length into the legal range (R9)
  always_comb begin
    if (maxVl == '0)
      vlEff = VL_W'(1);
    else if (maxVl > VL_W'(MAX_VL))
      vlEff = VL_W'(MAX_VL);
    else
      vlEff = maxVl;
  end

  assign extraImm      = vlEff - VL_W'(1);
  assign partialSum[0] = PROD_W'(extraImm);

  // extraImm * (subCode + 1) as a shift-add chain over the code bits (R5)
  for (genvar i = 0; i < SUB_W; i++) begin : g_subMul
    assign partialSum[i+1] = partialSum[i] +
        (subCode[i] ? (PROD_W'(extraImm) << i) : PROD_W'(0));
  end

  // Halfword count -> 32-bit words, rounded up (R4)
  assign halfWords = partialSum[SUB_W];
  assign wordCount = (halfWords + PROD_W'(1)) >> 1;
  assign lenFull   = FULL_W'(BASE_LEN_BYTES) + {wordCount, 2'b00};

  assign instLen = vecImmEn ? LEN_W'(lenFull) : LEN_W'(BASE_LEN_BYTES);

  // Fault when the end lies past the block edge; ending on the edge is legal (R7)
  assign endOffset  = END_W'(blockOffset) + END_W'(instLen);
  assign crossBlock = endOffset > END_W'(BLOCK_BYTES);

endmodule

// File: rtl/vimm_datapath.sv
module vimm_datapath #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned VL_W        = 7,
  parameter int unsigned MAX_VL      = 64,
  parameter int unsigned SUB_W       = 2,
  parameter int unsigned BLOCK_BYTES = 64,
  parameter int unsigned BLK_W       = 6,
  parameter int unsigned LEN_W       = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  vimm_pkg::vimmStrobe_t strobe,
  input  logic [ADDR_W-1:0]     curAddr,
  input  logic [VL_W-1:0]       maxVl,
  input  logic [SUB_W-1:0]      subCode,
  input  logic                  vecImmEn,
  output logic [ADDR_W-1:0]     nextAddr,
  output logic                  alignFault
);
  import vimm_pkg::*;

  logic [LEN_W-1:0] instLen;
  logic             crossBlock;

  vimm_len_calc #(
    .VL_W(VL_W), .MAX_VL(MAX_VL), .SUB_W(SUB_W),
    .BLOCK_BYTES(BLOCK_BYTES), .BLK_W(BLK_W), .LEN_W(LEN_W)
  ) u_lenCalc (
    .maxVl      (maxVl),
    .subCode    (subCode),
    .vecImmEn   (vecImmEn),
    .blockOffset(curAddr[BLK_W-1:0]),
    .instLen    (instLen),
    .crossBlock (crossBlock)
  );

  // Result registers: load on capture, hold otherwise (R1, R8)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nextAddr   <= '0;
      alignFault <= 1'b0;
    end else if (strobe.capture) begin
      nextAddr   <= curAddr + ADDR_W'(instLen);
      alignFault <= crossBlock;
    end
  end

  AST_DISABLED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture && !vecImmEn |=> nextAddr == $past(curAddr) + ADDR_W'(8)); // R3
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |=> nextAddr[1:0] == $past(curAddr[1:0])); // R4
  AST_SINGLE_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture && maxVl == VL_W'(1) |=> nextAddr == $past(curAddr) + ADDR_W'(8)); // R6
  AST_LONG_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture && instLen > LEN_W'(BLOCK_BYTES) |=> alignFault); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.idle |=> $stable(nextAddr) && $stable(alignFault)); // R8

endmodule

// File: rtl/vimm_ctrl.sv
module vimm_ctrl (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reqValid,
  output vimm_pkg::vimmStrobe_t strobe,
  output logic                  nextValid
);
  import vimm_pkg::*;

  always_comb begin
    strobe.capture = reqValid;
    strobe.idle    = ~reqValid;
  end

  // One-cycle valid pulse that follows each request (R2)
  always_ff @(posedge clk) begin
    if (!rst_n) nextValid <= 1'b0;
    else        nextValid <= reqValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> nextValid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !nextValid); // R2

endmodule

// File: rtl/vimm_skip_pc.sv
module vimm_skip_pc #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned VL_W        = 7,
  parameter int unsigned MAX_VL      = 64,
  parameter int unsigned SUB_W       = 2,
  parameter int unsigned BLOCK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [VL_W-1:0]   maxVl,
  input  logic [SUB_W-1:0]  subCode,
  input  logic              vecImmEn,
  output logic              nextValid,
  output logic [ADDR_W-1:0] nextAddr,
  output logic              alignFault
);
  import vimm_pkg::*;

  localparam int unsigned BLK_W   = $clog2(BLOCK_BYTES);
  localparam int unsigned MAX_LEN = BASE_LEN_BYTES +
      WORD_BYTES * (((MAX_VL - 1) * (2 ** SUB_W) * IMM_BYTES + WORD_BYTES - 1) / WORD_BYTES);
  localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);

  vimmStrobe_t strobe;

  vimm_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .strobe   (strobe),
    .nextValid(nextValid)
  );

  vimm_datapath #(
    .ADDR_W(ADDR_W), .VL_W(VL_W), .MAX_VL(MAX_VL), .SUB_W(SUB_W),
    .BLOCK_BYTES(BLOCK_BYTES), .BLK_W(BLK_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .curAddr   (curAddr),
    .maxVl     (maxVl),
    .subCode   (subCode),
    .vecImmEn  (vecImmEn),
    .nextAddr  (nextAddr),
    .alignFault(alignFault)
  );

endmodule

// File: tb/tb_vimm_skip_pc.sv
`timescale 1ns/1ps
module tb_vimm_skip_pc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] curAddr = '0;
  logic [6:0]  maxVl = '0;
  logic [1:0]  subCode = '0;
  logic        vecImmEn = 1'b0;
  logic        nextValid;
  logic [31:0] nextAddr;
  logic        alignFault;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vimm_skip_pc dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .curAddr(curAddr),
    .maxVl(maxVl), .subCode(subCode), .vecImmEn(vecImmEn),
    .nextValid(nextValid), .nextAddr(nextAddr), .alignFault(alignFault)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Reference length in bytes, computed in whole bytes
  function automatic int unsigned refLen(input int vl, input int sc, input bit en);
    int vlE, bytes;
    if (!en) return 8;
    vlE = (vl == 0) ? 1 : ((vl > 64) ? 64 : vl);
    bytes = (vlE - 1) * 2 * (sc + 1);
    return 8 + ((bytes + 3) / 4) * 4;
  endfunction

  function automatic string addrTag(input int vl, input int sc, input bit en);
    if (!en) return "R3";
    if (vl == 0) return "R9";
    if (vl == 1) return "R6";
    if (sc != 0) return "R5";
    return "R4";
  endfunction

  task automatic runReq(input logic [31:0] a, input int vl, input int sc, input bit en);
    logic [31:0] expA;
    bit expF;
    expA = a + refLen(vl, sc, en);
    expF = (int'(a[5:0]) + int'(refLen(vl, sc, en))) > 64;
    @(negedge clk);
    curAddr = a; maxVl = 7'(vl); subCode = 2'(sc); vecImmEn = en; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    curAddr = ~a; maxVl = 7'(vl + 17); subCode = ~subCode; vecImmEn = ~en;
    chk(nextValid === 1'b1, "R2", "valid pulse", longint'(nextValid), 1);
    chk(nextAddr === expA, addrTag(vl, sc, en), "next address", longint'(nextAddr), longint'(expA));
    chk(alignFault === expF, "R7", "align fault", longint'(alignFault), longint'(expF));
    @(negedge clk);
    chk(nextValid === 1'b0, "R2", "valid drops", longint'(nextValid), 0);
    chk(nextAddr === expA, "R8", "address holds", longint'(nextAddr), longint'(expA));
    chk(alignFault === expF, "R8", "fault holds", longint'(alignFault), longint'(expF));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] bases [3];
    int offs [8];
    bases = '{32'h8000_1000, 32'h0000_0000, 32'hFFFF_FFC0};
    offs  = '{0, 4, 8, 24, 40, 52, 56, 60};

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(nextValid === 1'b0, "R1", "reset valid", longint'(nextValid), 0);
    chk(nextAddr === 32'h0, "R1", "reset address", longint'(nextAddr), 0);
    chk(alignFault === 1'b0, "R1", "reset fault", longint'(alignFault), 0);
    rst_n = 1'b1;

    // Directed boundary cases
    runReq(32'h0000_1038, 1, 3, 1'b1);   // R6 / R7: ends exactly on block edge
    runReq(32'h0000_103C, 1, 0, 1'b0);   // R7: 8 bytes from offset 60 faults
    runReq(32'h0000_1000, 9, 3, 1'b1);   // R7: 8 + 64 bytes faults at offset 0
    runReq(32'h0000_1000, 8, 3, 1'b1);   // R4: 8 + 56 = 64, no fault
    runReq(32'h0000_2000, 127, 3, 1'b1); // R9: clamps to 64
    runReq(32'h0000_2000, 2, 0, 1'b1);   // R4: one halfword pads to a word

    // Exhaustive sweep over lengths and codes, sampled offsets and bases
    for (int vl = 0; vl <= 64; vl++)
      for (int sc = 0; sc < 4; sc++)
        for (int en = 0; en < 2; en++) begin
          int k;
          k = (vl * 4 + sc) % 8;
          runReq(bases[(vl + en) % 3] + 32'(offs[k]), vl, sc, en[0]);
        end

    // R2: back-to-back requests
    @(negedge clk);
    curAddr = 32'h0000_3004; maxVl = 7'd3; subCode = 2'd1; vecImmEn = 1'b1; reqValid = 1'b1;
    @(negedge clk);
    chk(nextValid === 1'b1, "R2", "b2b first valid", longint'(nextValid), 1);
    chk(nextAddr === 32'h0000_3014, "R2", "b2b first addr", longint'(nextAddr), 32'h3014);
    curAddr = 32'h0000_3100; maxVl = 7'd5; subCode = 2'd2; vecImmEn = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(nextValid === 1'b1, "R2", "b2b second valid", longint'(nextValid), 1);
    chk(nextAddr === 32'h0000_3120, "R2", "b2b second addr", longint'(nextAddr), 32'h3120);
    @(negedge clk);
    chk(nextValid === 1'b0, "R2", "b2b drop", longint'(nextValid), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule